// File: doc/BRIEF.md
# Byte-Synchronous Receiver with Deferred CRC Inclusion

This block is the receive side of a byte-oriented synchronous serial link. It watches a serial bit stream, one bit per clock-enable strobe, and searches for a programmable 8-bit sync character on every bit. Once the pattern is found, it frames the following bits into 8-bit characters, most significant bit first. Each character is written into a small receive queue that a CPU drains through a register port.

Every character is also held for one character time in a delay stage before it is folded into a CRC-16 checker. The delay gives software time to read a character and then decide whether that same character counts toward the CRC. A typical case is an end-of-message marker, which software leaves out of the CRC.

Each queued character carries a status entry. The entry holds the CRC-error flag as it stood when the character arrived, plus an overrun marker. Because of the delay, the verdict on the second check byte shows up in the entry of the first pad character after it.

Top module: `bsync_rx`

## Requirements
- R1: After reset the receiver is hunting, the queue is empty, CRC inclusion is off and the CRC register holds 0xFFFF; the status register (address 1) reads 0x08.
- R2: While hunting, the receiver compares the last 8 received bits (oldest bit as the MSB) with the sync pattern after every bit. The pattern is written at address 1 and is 0x16 after reset. A match leaves hunt mode without storing the sync character, and framing of the next character starts with the next bit.
- R3: After sync, every 8 bits form a character, first bit as the MSB, and it is appended to the queue. Reading address 0 returns the oldest character and removes it. Reading address 0 while the queue is empty returns 0x00 and removes nothing.
- R4: A character is folded into the CRC in the cycle the next character is assembled, using the inclusion setting (write address 0, bit 0) in force at that moment. A character read and then enabled before its successor arrives is therefore included.
- R5: A character whose successor arrives while inclusion is off is left out of the CRC. Characters after inclusion is turned back on are folded in again.
- R6: The CRC uses polynomial 0x1021, MSB first. A one-cycle pulse on `crc_preset` loads 0xFFFF. The error flag is 1 whenever the CRC register is non-zero.
- R7: The status entry stored with a character holds the error flag computed after the fold that this character's arrival triggers. For a correct message followed by its two check bytes, the entry of the first pad character shows 0. For a corrupted message it shows 1.
- R8: The queue holds 4 characters. If a character arrives while the queue is full and no read removes an entry in that cycle, the character is dropped, and the next character that is stored has its overrun bit set.
- R9: The status register reads bit 0 = head entry CRC error, bit 1 = head entry overrun, bit 2 = queue not empty, bit 3 = hunting, and all other bits 0. Bits 0 and 1 are 0 when the queue is empty. Reading status removes nothing. Reads of addresses 2 and 3 return 0.
- R10: Writing address 0 with bit 1 set returns the receiver to hunt mode, discards any partly assembled character and empties the delay stage.
- R11: If a character arrives into a full queue in the same cycle that a read removes the head, the character is stored, the queue stays full and no overrun is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_tick | input | 1 | One-cycle strobe: sample `rx_bit` as the next serial bit |
| rx_bit | input | 1 | Serial receive data |
| crc_preset | input | 1 | Loads the CRC register with all ones |
| cpu_rd | input | 1 | Register read strobe |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 2 | Register address: 0 data/control, 1 status/sync pattern |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data for the addressed register, combinational |

## Verification
The delicate cycle is the one in which a newly framed character is pushed into a full queue while the CPU removes the head. That single edge decides whether the character is kept or dropped as an overrun. The bench provokes it by watching its own model for a character that is due on the next edge, and asserting the data read in exactly that cycle. It judges the outcome by draining the queue afterwards: four entries must come out, the last one must be the new character, and no overrun bit may be set. The same per-cycle model also catches any ordering difference between a CPU change of CRC inclusion and the fold of the delayed character.

// File: rtl/bsync_pkg.sv
`timescale 1ns/1ps
// Shared constants, types and the CRC step function for the byte-sync receiver.
// Assumes 8-bit characters and a 16-bit CRC processed MSB first.
package bsync_pkg;
    localparam int CHAR_W = 8;
    localparam int CRC_W  = 16;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_DATA = 2'd0;   // read: data pop, write: control
    localparam logic [ADDR_W-1:0] A_STAT = 2'd1;   // read: status, write: sync pattern

    localparam int CTL_CRC_EN = 0;
    localparam int CTL_HUNT   = 1;

    typedef struct packed {
        logic crc_err;
        logic ovr;
    } err_ent_t;

    // Fold one character into the CRC, most significant bit first.
    function automatic logic [CRC_W-1:0] crc_fold(input logic [CRC_W-1:0] cur,
                                                  input logic [CHAR_W-1:0] ch,
                                                  input logic [CRC_W-1:0] poly);
        logic [CRC_W-1:0] r;
        logic             fb;
        r = cur;
        for (int i = CHAR_W - 1; i >= 0; i--) begin
            fb = r[CRC_W-1] ^ ch[i];
            r  = {r[CRC_W-2:0], 1'b0};
            if (fb) r = r ^ poly;
        end
        return r;
    endfunction
endpackage

// File: rtl/bsync_deser.sv
`timescale 1ns/1ps
// Hunt and character framing. Shifts serial bits in MSB first. While hunting it
// compares the last W bits with the sync pattern after every bit. After a match
// it emits one registered strobe per W bits.
// Assumes rx_tick is a single-cycle strobe synchronous to clk.
module bsync_deser #(
    parameter int             W        = 8,
    parameter logic [W-1:0]   SYNC_RST = 8'h16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_tick,
    input  logic         bit_in,
    input  logic         hunt_req,
    input  logic         sync_wr,
    input  logic [W-1:0] sync_wdata,
    output logic         hunting,
    output logic         char_vld,
    output logic [W-1:0] char_data
);
    localparam int CNT_W = $clog2(W);

    logic [W-1:0]     sr_q;
    logic [W-1:0]     sync_q;
    logic [CNT_W-1:0] bcnt_q;
    logic [W-1:0]     shifted;

    // Next shift register value with the incoming bit.
    always_comb shifted = {sr_q[W-2:0], bit_in};

    // Sync pattern register, written by the CPU.
    always_ff @(posedge clk) begin
        if (!rst_n)       sync_q <= SYNC_RST;
        else if (sync_wr) sync_q <= sync_wdata;
    end

    // Hunt / framing state and the character strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q      <= '0;
            bcnt_q    <= '0;
            hunting   <= 1'b1;
            char_vld  <= 1'b0;
            char_data <= '0;
        end else begin
            char_vld <= 1'b0;
            if (hunt_req) begin
                hunting <= 1'b1;
                bcnt_q  <= '0;
            end else if (bit_tick) begin
                sr_q <= shifted;
                if (hunting) begin
                    if (shifted == sync_q) begin
                        hunting <= 1'b0;
                        bcnt_q  <= '0;
                    end
                end else if (bcnt_q == CNT_W'(W - 1)) begin
                    char_vld  <= 1'b1;
                    char_data <= shifted;
                    bcnt_q    <= '0;
                end else begin
                    bcnt_q <= bcnt_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/bsync_crc.sv
`timescale 1ns/1ps
// One-character delay stage feeding a CRC-16 accumulator. The delayed character
// is folded in when the next character arrives, gated by the inclusion enable
// at that moment. err_next is the error flag that the same edge will produce.
module bsync_crc
    import bsync_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY = 16'h1021,
    parameter logic [CRC_W-1:0] INIT = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_vld,
    input  logic [CHAR_W-1:0] char_data,
    input  logic              crc_en,
    input  logic              preset,
    input  logic              flush,
    output logic [CRC_W-1:0]  crc_q,
    output logic              dly_valid,
    output logic              err_next
);
    logic [CHAR_W-1:0] dly_q;
    logic [CRC_W-1:0]  crc_d;

    // Next CRC: preset wins, otherwise fold the delayed character if allowed.
    always_comb begin
        if (preset)                              crc_d = INIT;
        else if (char_vld && dly_valid && crc_en) crc_d = crc_fold(crc_q, dly_q, POLY);
        else                                     crc_d = crc_q;
        err_next = |crc_d;
    end

    // CRC register.
    always_ff @(posedge clk) begin
        if (!rst_n) crc_q <= INIT;
        else        crc_q <= crc_d;
    end

    // Delay stage holding the most recent character.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_valid <= 1'b0;
            dly_q     <= '0;
        end else if (flush) begin
            dly_valid <= 1'b0;
        end else if (char_vld) begin
            dly_valid <= 1'b1;
            dly_q     <= char_data;
        end
    end
endmodule

// File: rtl/bsync_fifo.sv
`timescale 1ns/1ps
// Paired data and status queues sharing one write and one read pointer.
// A push is accepted when space exists or a pop frees a slot in the same cycle;
// otherwise the push is reported as dropped.
module bsync_fifo
    import bsync_pkg::*;
#(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               push_data,
    input  err_ent_t                   push_err,
    input  logic                       pop,
    output logic [W-1:0]               head_data,
    output err_ent_t                   head_err,
    output logic [$clog2(DEPTH+1)-1:0] cnt,
    output logic                       dropped
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     data_mem [DEPTH];
    err_ent_t         err_mem  [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_pop, do_push, has_space;

    // Accept/drop decisions for this cycle.
    always_comb begin
        do_pop    = pop && (cnt != '0);
        has_space = (cnt != CNT_W'(DEPTH)) || do_pop;
        do_push   = push && has_space;
        dropped   = push && !has_space;
        head_data = data_mem[rd_ptr];
        head_err  = err_mem[rd_ptr];
    end

    // Storage writes for both queues at the shared write pointer.
    always_ff @(posedge clk) begin
        if (do_push) begin
            data_mem[wr_ptr] <= push_data;
            err_mem[wr_ptr]  <= push_err;
        end
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            cnt <= cnt + CNT_W'(do_push) - CNT_W'(do_pop);
        end
    end
endmodule

// File: rtl/bsync_rx.sv
`timescale 1ns/1ps
// Byte-sync receiver top: framing, deferred CRC inclusion, paired data/status
// queues and a small CPU register port. Read data is combinational on the
// address. A read of the data address pops in the cycle the strobe is high.
module bsync_rx
    import bsync_pkg::*;
#(
    parameter int               DEPTH    = 4,
    parameter logic [CHAR_W-1:0] SYNC_RST = 8'h16,
    parameter logic [CRC_W-1:0]  CRC_POLY = 16'h1021,
    parameter logic [CRC_W-1:0]  CRC_INIT = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_tick,
    input  logic              rx_bit,
    input  logic              crc_preset,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [CHAR_W-1:0] cpu_wdata,
    output logic [CHAR_W-1:0] cpu_rdata
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic              hunting, char_vld, hunt_req, sync_wr, pop_req;
    logic [CHAR_W-1:0] char_data, head_data;
    logic              crc_en_q, ovr_pend_q, dly_valid, err_next, dropped, avail;
    logic [CRC_W-1:0]  crc_q;
    err_ent_t          head_err, push_err;
    logic [CNT_W-1:0]  fifo_cnt;

    // Decode CPU strobes.
    always_comb begin
        hunt_req = cpu_wr && (cpu_addr == A_DATA) && cpu_wdata[CTL_HUNT];
        sync_wr  = cpu_wr && (cpu_addr == A_STAT);
        pop_req  = cpu_rd && (cpu_addr == A_DATA);
        push_err = '{crc_err: err_next, ovr: ovr_pend_q};
        avail    = (fifo_cnt != '0);
    end

    // CRC inclusion enable, written through the control register.
    always_ff @(posedge clk) begin
        if (!rst_n)                             crc_en_q <= 1'b0;
        else if (cpu_wr && cpu_addr == A_DATA)  crc_en_q <= cpu_wdata[CTL_CRC_EN];
    end

    // Pending overrun mark, carried by the next stored character.
    always_ff @(posedge clk) begin
        if (!rst_n)        ovr_pend_q <= 1'b0;
        else if (dropped)  ovr_pend_q <= 1'b1;
        else if (char_vld) ovr_pend_q <= 1'b0;
    end

    // Register read multiplexer.
    always_comb begin
        case (cpu_addr)
            A_DATA:  cpu_rdata = avail ? head_data : '0;
            A_STAT:  cpu_rdata = {4'b0, hunting, avail, avail & head_err.ovr, avail & head_err.crc_err};
            default: cpu_rdata = '0;
        endcase
    end

    bsync_deser #(.W(CHAR_W), .SYNC_RST(SYNC_RST)) deser_i (
        .clk(clk), .rst_n(rst_n), .bit_tick(rx_tick), .bit_in(rx_bit),
        .hunt_req(hunt_req), .sync_wr(sync_wr), .sync_wdata(cpu_wdata),
        .hunting(hunting), .char_vld(char_vld), .char_data(char_data)
    );

    bsync_crc #(.POLY(CRC_POLY), .INIT(CRC_INIT)) crc_i (
        .clk(clk), .rst_n(rst_n), .char_vld(char_vld), .char_data(char_data),
        .crc_en(crc_en_q), .preset(crc_preset), .flush(hunt_req),
        .crc_q(crc_q), .dly_valid(dly_valid), .err_next(err_next)
    );

    bsync_fifo #(.W(CHAR_W), .DEPTH(DEPTH)) fifo_i (
        .clk(clk), .rst_n(rst_n), .push(char_vld), .push_data(char_data),
        .push_err(push_err), .pop(pop_req), .head_data(head_data),
        .head_err(head_err), .cnt(fifo_cnt), .dropped(dropped)
    );
endmodule

// File: rtl/bsync_rx_chk.sv
`timescale 1ns/1ps
// Property checker for bsync_rx, attached by bind. Observes ports and the
// signals passed between the framing, CRC and queue sub-blocks.
module bsync_rx_chk #(
    parameter int          DEPTH    = 4,
    parameter int          CNT_W    = 3,
    parameter logic [15:0] CRC_INIT = 16'hFFFF
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_rd,
    input logic [1:0]       cpu_addr,
    input logic             char_vld,
    input logic             pop_req,
    input logic [CNT_W-1:0] fifo_cnt,
    input logic             hunting,
    input logic             hunt_req,
    input logic             dly_valid,
    input logic             crc_preset,
    input logic [15:0]      crc_q
);
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CNT_W'(DEPTH)); // R8
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        char_vld && !pop_req && fifo_cnt == CNT_W'(DEPTH) |=> fifo_cnt == CNT_W'(DEPTH)); // R8
    AST_PUSH_POP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        char_vld && pop_req && fifo_cnt == CNT_W'(DEPTH) |=> fifo_cnt == CNT_W'(DEPTH)); // R11
    AST_STATUS_NOPOP: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rd && cpu_addr == 2'd1 && !char_vld |=> fifo_cnt == $past(fifo_cnt)); // R9
    AST_HUNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        hunt_req |=> hunting && !dly_valid); // R10
    AST_HUNT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        hunting |=> !char_vld); // R2
    AST_PRESET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        crc_preset |=> crc_q == CRC_INIT); // R6
endmodule

bind bsync_rx bsync_rx_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W), .CRC_INIT(CRC_INIT)) chk_i (
    .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_addr(cpu_addr),
    .char_vld(char_vld), .pop_req(pop_req), .fifo_cnt(fifo_cnt),
    .hunting(hunting), .hunt_req(hunt_req), .dly_valid(dly_valid),
    .crc_preset(crc_preset), .crc_q(crc_q)
);

// File: tb/bsync_rx_tb_top.sv
`timescale 1ns/1ps
// Bench for bsync_rx: behavioural per-cycle reference model plus directed checks.
module bsync_rx_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int QDEPTH     = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_tick = 1'b0, rx_bit = 1'b1, crc_preset = 1'b0;
    logic       cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [1:0] cpu_addr = 2'd0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bsync_rx dut_i (
        .clk(clk), .rst_n(rst_n), .rx_tick(rx_tick), .rx_bit(rx_bit),
        .crc_preset(crc_preset), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata)
    );

    // Reference CRC step (xor-in-then-shift form).
    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c ^ {d, 8'h00};
        for (int i = 0; i < 8; i++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
        return r;
    endfunction

    // ---------------- serial driver ----------------
    bit bit_q[$];
    int tcnt = 0;
    always @(negedge clk) begin
        if (tcnt >= TICK_DIV - 1 && bit_q.size() > 0) begin
            rx_tick = 1'b1;
            rx_bit  = bit_q.pop_front();
            tcnt    = 0;
        end else begin
            rx_tick = 1'b0;
            if (tcnt < TICK_DIV) tcnt++;
        end
    end

    // ---------------- reference model ----------------
    bit         m_hunt, m_cv, m_dlyv, m_en, m_ovp;
    logic [7:0] m_sr, m_cd, m_sync, m_dly;
    int         m_bcnt;
    logic [15:0] m_crc;
    logic [7:0] q_data[$];
    bit         q_err[$], q_ovr[$];

    always @(posedge clk) begin
        bit hreq, popv, full0, ocv, errv;
        logic [7:0] ocd;
        if (!rst_n) begin
            m_hunt = 1; m_cv = 0; m_dlyv = 0; m_en = 0; m_ovp = 0;
            m_sr = 0; m_cd = 0; m_sync = 8'h16; m_dly = 0; m_bcnt = 0; m_crc = 16'hFFFF;
            q_data.delete(); q_err.delete(); q_ovr.delete();
        end else begin
            ocv = m_cv; ocd = m_cd;
            hreq = cpu_wr && cpu_addr == 2'd0 && cpu_wdata[1];
            if (crc_preset) m_crc = 16'hFFFF;
            else if (ocv && m_dlyv && m_en) m_crc = ref_crc(m_crc, m_dly);
            errv = (m_crc != 16'h0);
            if (hreq) m_dlyv = 0;
            else if (ocv) begin m_dly = ocd; m_dlyv = 1; end
            popv  = cpu_rd && cpu_addr == 2'd0 && q_data.size() > 0;
            full0 = (q_data.size() == QDEPTH);
            if (popv) begin void'(q_data.pop_front()); void'(q_err.pop_front()); void'(q_ovr.pop_front()); end
            if (ocv) begin
                if (full0 && !popv) m_ovp = 1;
                else begin q_data.push_back(ocd); q_err.push_back(errv); q_ovr.push_back(m_ovp); m_ovp = 0; end
            end
            if (cpu_wr && cpu_addr == 2'd0) m_en = cpu_wdata[0];
            m_cv = 0;
            if (hreq) begin m_hunt = 1; m_bcnt = 0; end
            else if (rx_tick) begin
                m_sr = {m_sr[6:0], rx_bit};
                if (m_hunt) begin
                    if (m_sr == m_sync) begin m_hunt = 0; m_bcnt = 0; end
                end else if (m_bcnt == 7) begin m_cv = 1; m_cd = m_sr; m_bcnt = 0; end
                else m_bcnt++;
            end
            if (cpu_wr && cpu_addr == 2'd1) m_sync = cpu_wdata;
        end
    end

    function automatic logic [7:0] model_rdata(input logic [1:0] a);
        bit av;
        av = q_data.size() > 0;
        case (a)
            2'd0:    return av ? q_data[0] : 8'h00;
            2'd1:    return {4'b0, m_hunt, av, av & q_ovr[0], av & q_err[0]};
            default: return 8'h00;
        endcase
    endfunction

    // Per-cycle comparison, a quarter period after the falling edge.
    always begin
        @(negedge clk);
        #(CLK_PERIOD/4);
        if (rst_n && !done) begin
            n_cmp++;
            if (cpu_rdata !== model_rdata(cpu_addr)) begin
                n_bad++;
                $display("FAIL R9 cycle compare addr=%0d actual=%02h expected=%02h",
                         cpu_addr, cpu_rdata, model_rdata(cpu_addr));
            end
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk); cpu_wr = 0; cpu_wdata = 8'h00;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); cpu_rd = 1; cpu_addr = a;
        #(CLK_PERIOD/4); d = cpu_rdata;
        @(negedge clk); cpu_rd = 0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) bit_q.push_back(b[i]);
    endtask

    task automatic wait_avail();
        logic [7:0] s;
        for (int i = 0; i < 2000; i++) begin
            rd(2'd1, s);
            if (s[2]) return;
        end
    endtask

    task automatic wait_line_idle();
        while (bit_q.size() > 0) @(negedge clk);
        repeat (TICK_DIV + 4) @(negedge clk);
    endtask

    task automatic pulse_preset();
        @(negedge clk); crc_preset = 1;
        @(negedge clk); crc_preset = 0;
    endtask

    // One framed message: B C D E F G H with E,F the check bytes over B,C.
    task automatic run_msg(input logic [7:0] sync, input bit drop_d, input bit corrupt,
                           input logic exp_err, input string tag);
        logic [7:0] b[7];
        logic [15:0] c;
        logic [7:0] s, d;
        wr(2'd1, sync);
        wr(2'd0, 8'h02);
        rd(2'd1, s);
        chk("R10 hunt bit after hunt command", s, 8'h08);
        pulse_preset();
        b[0] = 8'h3C; b[1] = 8'hA5; b[2] = 8'h0D;
        c = ref_crc(ref_crc(16'hFFFF, b[0]), b[1]);
        b[3] = c[15:8]; b[4] = c[7:0] ^ {7'b0, corrupt};
        b[5] = 8'h55; b[6] = 8'hAA;
        send_byte(8'hFF); send_byte(sync);
        foreach (b[k]) send_byte(b[k]);
        for (int k = 0; k < 7; k++) begin
            wait_avail();
            rd(2'd1, s);
            if (k == 5) chk(tag, {7'b0, s[0]}, {7'b0, exp_err});
            rd(2'd0, d);
            chk("R3 received character", d, b[k]);
            if (k == 0) wr(2'd0, 8'h01);
            if (k == 2 && drop_d) wr(2'd0, 8'h00);
            if (k == 3 && drop_d) wr(2'd0, 8'h01);
        end
    endtask

    // ---------------- main sequence ----------------
    initial begin
        logic [7:0] s, d;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        rd(2'd1, s); chk("R1 status after reset", s, 8'h08);
        rd(2'd0, d); chk("R3 empty read returns zero", d, 8'h00);
        rd(2'd2, d); chk("R9 unused address reads zero", d, 8'h00);

        run_msg(8'h16, 1, 0, 1'b0, "R4 R5 R7 good message, marker excluded");
        run_msg(8'h16, 0, 0, 1'b1, "R5 marker included gives error");
        run_msg(8'h2D, 1, 1, 1'b1, "R6 R2 corrupted check byte with new sync");

        // R2: idle ones never match; nothing stored while hunting.
        wr(2'd0, 8'h02);
        send_byte(8'hFF); send_byte(8'hFF);
        wait_line_idle();
        rd(2'd1, s); chk("R2 no characters while hunting", s, 8'h08);

        // R8: overrun with a full queue.
        send_byte(8'h2D);
        for (int k = 0; k < 6; k++) send_byte(8'h10 + 8'(k));
        wait_line_idle();
        rd(2'd1, s); chk("R9 status no pop (1)", s & 8'h06, 8'h04);
        rd(2'd1, s); chk("R9 status no pop (2)", s & 8'h06, 8'h04);
        for (int k = 0; k < 4; k++) begin
            rd(2'd1, s); chk("R8 no overrun on stored entries", {7'b0, s[1]}, 8'h00);
            rd(2'd0, d); chk("R8 queue order before overrun", d, 8'h10 + 8'(k));
        end
        send_byte(8'h77);
        wait_line_idle();
        rd(2'd1, s); chk("R8 overrun marked on next entry", {7'b0, s[1]}, 8'h01);
        rd(2'd0, d); chk("R8 character after overrun", d, 8'h77);

        // R11: push into a full queue in the same cycle as a pop.
        for (int k = 0; k < 4; k++) send_byte(8'h20 + 8'(k));
        wait_line_idle();
        send_byte(8'h99);
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (m_cv) break;
        end
        cpu_rd = 1; cpu_addr = 2'd0;
        #(CLK_PERIOD/4); d = cpu_rdata;
        @(negedge clk); cpu_rd = 0;
        chk("R11 head popped in push cycle", d, 8'h20);
        for (int k = 1; k < 4; k++) begin
            rd(2'd0, d); chk("R11 remaining order", d, 8'h20 + 8'(k));
        end
        rd(2'd1, s); chk("R11 new character kept, no overrun", s & 8'h06, 8'h04);
        rd(2'd0, d); chk("R11 new character value", d, 8'h99);
        rd(2'd1, s); chk("R9 empty status", s, 8'h00);

        // R10: hunt command resumes hunting.
        wr(2'd0, 8'h02);
        rd(2'd1, s); chk("R10 hunting after command", s, 8'h08);

        repeat (4) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule